// File: doc/BRIEF.md
# Two-Write Write-Once-Memory Page Codec

This block lets a group of binary storage cells, which can only be set and never individually cleared, hold a 2-bit value twice before the group must be erased. Every 2-bit value occupies one triple of cells. The first write sets at most one cell of the triple. The second write sets further cells so that the triple reads back as the new value. Across both writes, 3 cells carry 4 data bits.

A page is a row of `LANES` independent triples. They share one write strobe and one generation code. The code tells the encoder whether this is the first write, the second write, or a write past the second. On a write, the caller supplies the new 2-bit value and the current contents of each triple, read before the write. One cycle later the block presents the cell pattern to program and a per-triple error flag. A separate combinational read path turns any cell triple back into its 2-bit value.

Top module: `wom_page_codec`

## Requirements
- R1: With generation code 0 (first write) on an erased triple, the output pattern (bits 2..0) is 000 for value 00, 100 for 01, 010 for 10 and 001 for 11.
- R2: With generation code 1 (second write), if the new value equals the value the old triple decodes to, the output pattern equals the old triple.
- R3: With generation code 1, if the new value differs from the decoded old value, the output pattern is the bitwise complement of the R1 pattern of the new value, provided this clears no set cell.
- R4: The read path decodes a triple with at most one set cell by the inverse of the R1 map. It decodes a triple with two or more set cells by complementing the triple first and then applying the inverse of the R1 map.
- R5: The output pattern never has a cell at 0 where the old triple had a 1.
- R6: When the candidate pattern would clear a set cell, the lane's error flag is 1 and its output pattern equals its old triple.
- R7: A generation code of 2 or 3 sets the error flag on every lane, and each output pattern equals that lane's old triple.
- R8: Value, old triple and generation are captured on the strobe. The valid output is high exactly in the cycle after a strobe. Patterns and error flags hold until the next strobe.
- R9: During and right after reset, the valid output, all output patterns and all error flags are 0.
- R10: Each lane uses only its own value and old triple, together with the shared generation code.
- R11: Whenever a lane reports no error on a first or second write, its output pattern decodes back to the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_strobe_i | input | 1 | Capture a write request this cycle |
| wr_gen_i | input | 2 | Generation: 0 first write, 1 second write, 2 or 3 beyond |
| wr_msg_i | input | 2*LANES | New 2-bit value per lane, lane i at bits [2i+1:2i] |
| wr_old_i | input | 3*LANES | Triple contents read before the write, lane i at [3i+2:3i] |
| rd_cells_i | input | 3*LANES | Triples to decode on the read path |
| rd_msg_o | output | 2*LANES | Decoded value per triple (combinational) |
| wr_valid_o | output | 1 | Result valid, one cycle after the strobe |
| wr_cells_o | output | 3*LANES | Pattern to program per lane |
| wr_err_o | output | LANES | Per-lane illegal-write flag |

## Verification
On every clocked cycle, the assertions check that no output pattern drops a cell set in the captured old triple. They also check that an error leaves the triple untouched, that codes 2 and 3 always raise errors, that error-free writes decode back to their value, and that the valid pulse and the hold of the results follow the strobe. Only the bench scenarios can show the actual code tables: the exact first-write patterns, the choice between keeping and complementing on a second write, and the decoding of all eight triple values. The bench also shows that lanes with different histories in the same page do not affect one another.

// File: rtl/wom_codec_pkg.sv
// Package wom_codec_pkg
// Shared widths, generation codes and the first-write map for the
// two-write write-once-memory codec. Assumes a 2-bit value per 3-cell triple.
package wom_codec_pkg;

    localparam int MSG_W  = 2;
    localparam int CELL_W = 3;
    localparam int GEN_W  = 2;

    typedef logic [MSG_W-1:0]  msg_t;
    typedef logic [CELL_W-1:0] cells_t;
    typedef logic [GEN_W-1:0]  gen_t;

    localparam gen_t GEN_FIRST  = 2'd0;
    localparam gen_t GEN_SECOND = 2'd1;

    // Pattern of the first write: at most one cell set
    function automatic cells_t first_pattern(input msg_t m);
        case (m)
            2'b01:   first_pattern = 3'b100;
            2'b10:   first_pattern = 3'b010;
            2'b11:   first_pattern = 3'b001;
            default: first_pattern = 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/wom_pattern_decoder.sv
// Module wom_pattern_decoder
// Turns any 3-cell triple into its stored 2-bit value. Light triples
// (weight 0 or 1) map directly; heavy triples (weight 2 or 3) are
// complemented first. Purely combinational; every triple value is legal.
module wom_pattern_decoder
    import wom_codec_pkg::*;
(
    input  cells_t cells_i,
    output msg_t   msg_o
);

    logic [1:0] weight;
    cells_t     light;

    // Count set cells and fold heavy triples back to light form
    always_comb begin
        weight = 2'(cells_i[0]) + 2'(cells_i[1]) + 2'(cells_i[2]);
        light  = (weight >= 2'd2) ? ~cells_i : cells_i;
    end

    // Inverse of the first-write map
    always_comb begin
        case (light)
            3'b100:  msg_o = 2'b01;
            3'b010:  msg_o = 2'b10;
            3'b001:  msg_o = 2'b11;
            default: msg_o = 2'b00;
        endcase
    end

endmodule

// File: rtl/wom_write_encoder.sv
// Module wom_write_encoder
// Computes the pattern for one triple from the generation, the new value
// and the old contents. An illegal request (generation beyond the second,
// or a candidate that would clear a set cell) returns the old triple with
// the error flag raised. Combinational.
module wom_write_encoder
    import wom_codec_pkg::*;
(
    input  gen_t   gen_i,
    input  msg_t   msg_i,
    input  cells_t old_i,
    output cells_t cells_o,
    output logic   err_o
);

    msg_t   cur_msg;
    cells_t cand;
    logic   beyond;
    logic   clears;

    wom_pattern_decoder u_cur_dec (
        .cells_i (old_i),
        .msg_o   (cur_msg)
    );

    // Candidate pattern by generation
    always_comb begin
        beyond = 1'b0;
        case (gen_i)
            GEN_FIRST:  cand = first_pattern(msg_i);
            GEN_SECOND: cand = (cur_msg == msg_i) ? old_i : ~first_pattern(msg_i);
            default: begin
                cand   = old_i;
                beyond = 1'b1;
            end
        endcase
    end

    // Legality check and safe fallback to the old triple
    always_comb begin
        clears  = |(old_i & ~cand);
        err_o   = beyond | clears;
        cells_o = err_o ? old_i : cand;
    end

endmodule

// File: rtl/wom_lane_slice.sv
// Module wom_lane_slice
// One triple of the page: captures value and old contents on the strobe,
// encodes them with the shared registered generation, and decodes the
// read-path triple. Assumes gen_q is captured by the parent on the same strobe.
module wom_lane_slice
    import wom_codec_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   strobe_i,
    input  gen_t   gen_q,
    input  msg_t   msg_i,
    input  cells_t old_i,
    input  cells_t rd_cells_i,
    output msg_t   rd_msg_o,
    output cells_t cells_o,
    output logic   err_o
);

    msg_t   msg_q;
    cells_t old_q;
    msg_t   chk_msg;

    // Capture the write request of this lane
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_q <= '0;
            old_q <= '0;
        end else if (strobe_i) begin
            msg_q <= msg_i;
            old_q <= old_i;
        end
    end

    wom_write_encoder u_enc (
        .gen_i   (gen_q),
        .msg_i   (msg_q),
        .old_i   (old_q),
        .cells_o (cells_o),
        .err_o   (err_o)
    );

    wom_pattern_decoder u_rd_dec (
        .cells_i (rd_cells_i),
        .msg_o   (rd_msg_o)
    );

    wom_pattern_decoder u_chk_dec (
        .cells_i (cells_o),
        .msg_o   (chk_msg)
    );

    assert_never_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cells_o & old_q) == old_q);

    assert_err_keeps_old_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (cells_o == old_q));

    assert_beyond_second_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_q > GEN_SECOND) |-> (err_o && cells_o == old_q));

    assert_round_trip_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_o && gen_q <= GEN_SECOND) |-> (chk_msg == msg_q));

endmodule

// File: rtl/wom_page_codec.sv
// Module wom_page_codec
// Page-wide two-write write-once-memory codec: LANES independent triples
// sharing one strobe and one generation code. Results are valid one cycle
// after the strobe and held until the next one.
module wom_page_codec
    import wom_codec_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_strobe_i,
    input  logic [GEN_W-1:0]        wr_gen_i,
    input  logic [MSG_W*LANES-1:0]  wr_msg_i,
    input  logic [CELL_W*LANES-1:0] wr_old_i,
    input  logic [CELL_W*LANES-1:0] rd_cells_i,
    output logic [MSG_W*LANES-1:0]  rd_msg_o,
    output logic                    wr_valid_o,
    output logic [CELL_W*LANES-1:0] wr_cells_o,
    output logic [LANES-1:0]        wr_err_o
);

    gen_t gen_q;

    // Shared generation capture and one-cycle valid pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_q      <= GEN_FIRST;
            wr_valid_o <= 1'b0;
        end else begin
            wr_valid_o <= wr_strobe_i;
            if (wr_strobe_i) gen_q <= wr_gen_i;
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        wom_lane_slice u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .strobe_i   (wr_strobe_i),
            .gen_q      (gen_q),
            .msg_i      (wr_msg_i[i*MSG_W +: MSG_W]),
            .old_i      (wr_old_i[i*CELL_W +: CELL_W]),
            .rd_cells_i (rd_cells_i[i*CELL_W +: CELL_W]),
            .rd_msg_o   (rd_msg_o[i*MSG_W +: MSG_W]),
            .cells_o    (wr_cells_o[i*CELL_W +: CELL_W]),
            .err_o      (wr_err_o[i])
        );
    end

    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe_i |=> wr_valid_o);

    assert_valid_only_after_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> $past(wr_strobe_i));

    assert_hold_results_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_strobe_i) |-> ($stable(wr_cells_o) && $stable(wr_err_o)));

endmodule

// File: tb/wom_page_codec_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected results, the monitor
// compares them when the valid output appears.
module wom_page_codec_bench;

    localparam int LANES = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_strobe_i = 1'b0;
    logic [1:0]        wr_gen_i = '0;
    logic [2*LANES-1:0] wr_msg_i = '0;
    logic [3*LANES-1:0] wr_old_i = '0;
    logic [3*LANES-1:0] rd_cells_i = '0;
    logic [2*LANES-1:0] rd_msg_o;
    logic              wr_valid_o;
    logic [3*LANES-1:0] wr_cells_o;
    logic [LANES-1:0]  wr_err_o;

    int n_vec = 0;
    int n_bad = 0;

    typedef struct {
        logic [3*LANES-1:0] cells;
        logic [LANES-1:0]   err;
        string              tag;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    wom_page_codec #(.LANES(LANES)) u_wom_page_codec (
        .clk(clk), .rst_n(rst_n), .wr_strobe_i(wr_strobe_i), .wr_gen_i(wr_gen_i),
        .wr_msg_i(wr_msg_i), .wr_old_i(wr_old_i), .rd_cells_i(rd_cells_i),
        .rd_msg_o(rd_msg_o), .wr_valid_o(wr_valid_o), .wr_cells_o(wr_cells_o),
        .wr_err_o(wr_err_o)
    );

    function automatic logic [2:0] m_first(input logic [1:0] m);
        case (m)
            2'b00: return 3'b000;
            2'b01: return 3'b100;
            2'b10: return 3'b010;
            default: return 3'b001;
        endcase
    endfunction

    function automatic logic [1:0] m_dec(input logic [2:0] c);
        int w;
        logic [2:0] n;
        w = int'(c[0]) + int'(c[1]) + int'(c[2]);
        n = (w >= 2) ? ~c : c;
        if (n == 3'b100) return 2'b01;
        if (n == 3'b010) return 2'b10;
        if (n == 3'b001) return 2'b11;
        return 2'b00;
    endfunction

    // Returns {err, pattern}
    function automatic logic [3:0] m_write(input logic [1:0] g, input logic [1:0] m,
                                           input logic [2:0] old);
        logic [2:0] cand;
        if (g >= 2'd2) return {1'b1, old};
        if (g == 2'd0) cand = m_first(m);
        else cand = (m_dec(old) == m) ? old : ~m_first(m);
        if ((old & ~cand) != 3'b000) return {1'b1, old};
        return {1'b0, cand};
    endfunction

    function automatic logic [2:0] first_c(input int m);
        return m_first(2'(m));
    endfunction

    task automatic do_write(input logic [1:0] g, input logic [2*LANES-1:0] msgs,
                            input logic [3*LANES-1:0] olds, input string tag);
        exp_t e;
        logic [3:0] r;
        e.tag = tag;
        for (int i = 0; i < LANES; i++) begin
            r = m_write(g, msgs[2*i +: 2], olds[3*i +: 3]);
            e.cells[3*i +: 3] = r[2:0];
            e.err[i] = r[3];
        end
        @(negedge clk);
        wr_gen_i = g; wr_msg_i = msgs; wr_old_i = olds; wr_strobe_i = 1'b1;
        sb_q.push_back(e);
        @(negedge clk);
        wr_strobe_i = 1'b0;
        wr_msg_i = '1; wr_old_i = '1; wr_gen_i = 2'd3;
    endtask

    // Monitor: compare every valid result against the scoreboard
    always @(negedge clk) begin
        if (rst_n && wr_valid_o) begin
            if (sb_q.size() == 0) begin
                n_vec++; n_bad++;
                $display("FAIL R8 valid without strobe: actual valid=1 expected 0");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                for (int i = 0; i < LANES; i++) begin
                    n_vec++;
                    if (wr_cells_o[3*i +: 3] !== e.cells[3*i +: 3] || wr_err_o[i] !== e.err[i]) begin
                        n_bad++;
                        $display("FAIL %s lane %0d: actual cells=%b err=%b expected cells=%b err=%b",
                                 e.tag, i, wr_cells_o[3*i +: 3], wr_err_o[i],
                                 e.cells[3*i +: 3], e.err[i]);
                    end
                end
            end
        end
    end

    task automatic chk_dec(input logic [3*LANES-1:0] cells, input string tag);
        @(negedge clk);
        rd_cells_i = cells;
        #1;
        for (int i = 0; i < LANES; i++) begin
            n_vec++;
            if (rd_msg_o[2*i +: 2] !== m_dec(cells[3*i +: 3])) begin
                n_bad++;
                $display("FAIL %s lane %0d cells %b: actual %b expected %b", tag, i,
                         cells[3*i +: 3], rd_msg_o[2*i +: 2], m_dec(cells[3*i +: 3]));
            end
        end
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [3*LANES-1:0] last_cells;
        logic [2*LANES-1:0] msgs;
        logic [3*LANES-1:0] olds;
        repeat (3) @(negedge clk);
        // R9: reset state
        n_vec++;
        if (wr_valid_o !== 1'b0 || wr_cells_o !== '0 || wr_err_o !== '0) begin
            n_bad++;
            $display("FAIL R9 reset: actual v=%b c=%b e=%b expected 0", wr_valid_o, wr_cells_o, wr_err_o);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_vec++;
        if (wr_valid_o !== 1'b0 || wr_cells_o !== '0 || wr_err_o !== '0) begin
            n_bad++;
            $display("FAIL R9 after reset: actual v=%b c=%b e=%b expected 0", wr_valid_o, wr_cells_o, wr_err_o);
        end

        // R1 first writes, R10 lanes carry different values
        do_write(2'd0, 8'b11_10_01_00, '0, "R1 first");
        do_write(2'd0, 8'b00_01_10_11, '0, "R1 first rev");

        // R2 and R3 second writes over every first value
        for (int a = 0; a < 4; a++) begin
            olds = {first_c(a), first_c(a), first_c(a), first_c(a)};
            do_write(2'd1, 8'b11_10_01_00, olds, "R2_R3 second");
        end

        // R2 on heavy triples, R3 to 00, R6 illegal second changes
        olds = {3'b111, 3'b110, 3'b101, 3'b011};
        do_write(2'd1, 8'b00_11_10_01, olds, "R2 heavy keep");
        do_write(2'd1, 8'b00_00_00_00, olds, "R3 heavy to 00");
        do_write(2'd1, 8'b01_01_11_10, olds, "R6 heavy clear");

        // R6 first write over set cells, R10 mixed lanes
        do_write(2'd0, 8'b11_11_01_01, {3'b001, 3'b000, 3'b100, 3'b010}, "R6_R10 first dirty");

        // R7 beyond the second generation
        do_write(2'd2, 8'b11_10_01_00, {3'b000, 3'b100, 3'b011, 3'b111}, "R7 gen2");
        do_write(2'd3, 8'b01_01_01_01, {3'b010, 3'b001, 3'b000, 3'b110}, "R7 gen3");

        // R8 hold: results stay while no strobe
        msgs = 8'b10_01_11_00;
        do_write(2'd0, msgs, '0, "R8 write");
        @(negedge clk);
        last_cells = {first_c(2), first_c(1), first_c(3), first_c(0)};
        repeat (3) begin
            @(negedge clk);
            n_vec++;
            if (wr_valid_o !== 1'b0 || wr_cells_o !== last_cells || wr_err_o !== '0) begin
                n_bad++;
                $display("FAIL R8 hold: actual v=%b c=%b expected v=0 c=%b", wr_valid_o, wr_cells_o, last_cells);
            end
        end

        // R4 decoder over all eight triples; R11 round trip of written data
        chk_dec({3'b001, 3'b010, 3'b100, 3'b000}, "R4 light");
        chk_dec({3'b111, 3'b110, 3'b101, 3'b011}, "R4 heavy");
        chk_dec({3'b011, 3'b001, 3'b111, 3'b100}, "R11 mix");

        repeat (4) @(negedge clk);
        n_vec++;
        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL R8 missing results: actual pending=%0d expected 0", sb_q.size());
        end
        summary();
    end

endmodule